// File: doc/BRIEF.md
# Error Counter Latch Controller

This block decides when a line framer's running error counters are frozen into holding registers and cleared for the next accumulation period. Each latch is atomic. In one clock edge the current running counts move into the holding registers, the running counters restart, and a one-cycle done pulse goes out. The block keeps two running counters. The first counts line-code violations, with excessive-zero events added when software asks for them. The second counts framing errors: framing-bit errors in one or both framing-bit positions, or multiframe sync losses, depending on configuration and line mode.

An 8-bit configuration register sets the update policy. In automatic mode a latch fires on one of three sources: the local one-second strobe, the rising edge of a one-second timer level shared from another port, or a frame-count interval. That interval is 333 frames for T1 or 500 frames for E1. In manual mode a latch fires on a 0-to-1 change of a software bit, or on the rising edge of an external latch input. Event and tick inputs are single-cycle strobes. There is no back-pressure anywhere. The holding registers are plain outputs that are valid from the cycle the done pulse is high until the next done pulse.

Configuration bit map (bit: meaning): 0 manual mode, 1 short frame interval, 2 manual update toggle, 3 external latch select, 4 shared second select, 5 include excessive zeros, 6 report both framing-bit positions, 7 count multiframe sync loss.

Top module: `errcnt_latch_ctrl`

## Requirements
- R1: After reset the configuration register is 0 (automatic mode, one-second interval, local tick), both holding outputs are 0 and upd_done is low.
- R2: In automatic mode with bit 1 = 0 and bit 4 = 0, a sec_tick strobe sampled on clock edge k makes upd_done high for exactly the cycle after edge k+1.
- R3: Each latch loads a holding output with the number of its counter's increments since the previous latch, and the holding outputs do not change between latches.
- R4: An increment sampled on the same edge as a latch goes into the new period, so no event is lost or counted twice across a latch.
- R5: A running counter saturates at 2^CW-1 and does not wrap.
- R6: In automatic mode with bit 1 = 1, a latch fires on every 333rd frame_tick when line_e1 = 0 and on every 500th frame_tick when line_e1 = 1. sec_tick is ignored in this setting.
- R7: A change of bit 1 or of line_e1 restarts the frame interval, so the first interval after the change is a full one.
- R8: In manual mode with bit 3 = 0, each 0-to-1 change of bit 2 produces exactly one latch. Rewriting 1 over 1, or writing 0, produces none.
- R9: In manual mode with bit 3 = 1, each rising edge of ext_latch produces exactly one latch, and bit 2 has no effect. With bit 3 = 0, ext_latch has no effect.
- R10: In automatic mode with bit 4 = 1 and bit 1 = 0, latches follow the rising edges of the sec_shared level, and sec_tick is ignored.
- R11: In manual mode, sec_tick, sec_shared and frame_tick cause no latch.
- R12: The line-code counter increments on ev_lcv, and also on ev_xz when bit 5 = 1. It counts at most one per cycle.
- R13: When line_e1 = 0, the framing counter behaves as follows. It counts ev_mf_loss when bit 7 = 1. Otherwise it counts ev_ft_err, and also ev_fs_err when bit 6 = 1. When line_e1 = 1 it counts ev_ft_err only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| line_e1 | input | 1 | Line mode, 0 = T1, 1 = E1 |
| sec_tick | input | 1 | Local one-second strobe |
| sec_shared | input | 1 | Shared one-second timer level from another port |
| frame_tick | input | 1 | One strobe per received frame |
| ext_latch | input | 1 | External latch request level |
| ev_lcv | input | 1 | Line-code violation strobe |
| ev_xz | input | 1 | Excessive-zero strobe |
| ev_ft_err | input | 1 | Terminal framing-bit error strobe |
| ev_fs_err | input | 1 | Signaling framing-bit error strobe |
| ev_mf_loss | input | 1 | Multiframe sync loss strobe |
| lcv_count | output | CW | Latched line-code violation count |
| frm_count | output | CW | Latched framing error count |
| upd_done | output | 1 | One-cycle pulse after each latch |

## Verification
The assertions assume latch sources never request two latches on back-to-back cycles. Under that assumption every done pulse follows exactly one update request, and a running counter that holds one or zero right after a latch reflects only the new period. The stimulus spaces every tick, toggle and external edge several cycles apart. Event strobes are delivered one per cycle on at most one input at a time, so the expected counts follow by plain arithmetic.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

  typedef struct packed {
    logic mf_sel;      // bit 7: framing counter counts multiframe sync loss (T1)
    logic fs_rep;      // bit 6: add signaling framing-bit errors (T1)
    logic xz_inc;      // bit 5: add excessive-zero events to line-code count
    logic shared_sec;  // bit 4: follow shared one-second timer
    logic ext_sel;     // bit 3: external pin drives manual latch
    logic man_toggle;  // bit 2: software manual latch bit
    logic short_int;   // bit 1: frame-count interval instead of one second
    logic manual;      // bit 0: manual accumulation mode
  } ecfg_t;

  localparam int unsigned NCNT    = 2;
  localparam int unsigned IDX_LCV = 0;
  localparam int unsigned IDX_FRM = 1;

endpackage

// File: rtl/errcnt_cfg_reg.sv
module errcnt_cfg_reg
  import errcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ecfg_t      cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= ecfg_t'(wdata);
  end

endmodule

// File: rtl/errcnt_upd_gen.sv
module errcnt_upd_gen
  import errcnt_pkg::*;
#(
  parameter int unsigned FR_T1 = 333,
  parameter int unsigned FR_E1 = 500
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ecfg_t cfg,
  input  logic  line_e1,
  input  logic  sec_tick,
  input  logic  sec_shared,
  input  logic  frame_tick,
  input  logic  ext_latch,
  output logic  upd
);

  localparam int unsigned FR_MAX = (FR_T1 > FR_E1) ? FR_T1 : FR_E1;
  localparam int unsigned FW     = (FR_MAX > 2) ? $clog2(FR_MAX) : 1;
  localparam logic [FW-1:0] LIM_T1 = FW'(FR_T1 - 1);
  localparam logic [FW-1:0] LIM_E1 = FW'(FR_E1 - 1);

  logic          man_q, ext_q, sh_q, short_q, mode_q;
  logic [FW-1:0] fcnt;
  logic [FW-1:0] lim;
  logic          restart, fire, man_rise, ext_rise, sh_rise;
  logic          timed_trig, manual_trig, trig;

  // previous-value flops for edge detection and interval restart
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      man_q   <= 1'b0;
      ext_q   <= 1'b0;
      sh_q    <= 1'b0;
      short_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      man_q   <= cfg.man_toggle;
      ext_q   <= ext_latch;
      sh_q    <= sec_shared;
      short_q <= cfg.short_int;
      mode_q  <= line_e1;
    end
  end

  always_comb begin
    lim      = line_e1 ? LIM_E1 : LIM_T1;
    restart  = (short_q != cfg.short_int) || (mode_q != line_e1);
    fire     = cfg.short_int && frame_tick && !restart && (fcnt == lim);
    man_rise = cfg.man_toggle && !man_q;
    ext_rise = ext_latch && !ext_q;
    sh_rise  = sec_shared && !sh_q;
  end

  // frame interval counter
  always_ff @(posedge clk) begin
    if (!rst_n)                      fcnt <= '0;
    else if (restart || !cfg.short_int) fcnt <= '0;
    else if (frame_tick)             fcnt <= (fcnt == lim) ? '0 : fcnt + 1'b1;
  end

  always_comb begin
    if (cfg.short_int)       timed_trig = fire;
    else if (cfg.shared_sec) timed_trig = sh_rise;
    else                     timed_trig = sec_tick;
    manual_trig = cfg.ext_sel ? ext_rise : man_rise;
    trig        = cfg.manual ? manual_trig : timed_trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upd <= 1'b0;
    else        upd <= trig;
  end

endmodule

// File: rtl/errcnt_cnt_bank.sv
module errcnt_cnt_bank #(
  parameter int unsigned N  = 2,
  parameter int unsigned CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    inc,
  input  logic            latch,
  output logic [N*CW-1:0] run,
  output logic [N*CW-1:0] hold,
  output logic            done
);

  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CW-1:0] r_q, h_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
        h_q <= '0;
      end else if (latch) begin
        h_q <= r_q;
        r_q <= inc[g] ? CW'(1) : '0;
      end else if (inc[g] && r_q != MAXV) begin
        r_q <= r_q + 1'b1;
      end
    end

    assign run[g*CW +: CW]  = r_q;
    assign hold[g*CW +: CW] = h_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= latch;
  end

endmodule

// File: rtl/errcnt_latch_ctrl.sv
module errcnt_latch_ctrl
  import errcnt_pkg::*;
#(
  parameter int unsigned CW    = 16,
  parameter int unsigned FR_T1 = 333,
  parameter int unsigned FR_E1 = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          line_e1,
  input  logic          sec_tick,
  input  logic          sec_shared,
  input  logic          frame_tick,
  input  logic          ext_latch,
  input  logic          ev_lcv,
  input  logic          ev_xz,
  input  logic          ev_ft_err,
  input  logic          ev_fs_err,
  input  logic          ev_mf_loss,
  output logic [CW-1:0] lcv_count,
  output logic [CW-1:0] frm_count,
  output logic          upd_done
);

  ecfg_t                cfg;
  logic                 upd;
  logic [NCNT-1:0]      inc;
  logic [NCNT*CW-1:0]   run_vec, hold_vec;
  logic [CW-1:0]        lcv_run, frm_run;

  errcnt_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  errcnt_upd_gen #(.FR_T1(FR_T1), .FR_E1(FR_E1)) u_upd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .line_e1    (line_e1),
    .sec_tick   (sec_tick),
    .sec_shared (sec_shared),
    .frame_tick (frame_tick),
    .ext_latch  (ext_latch),
    .upd        (upd)
  );

  // event selection per counter
  always_comb begin
    inc          = '0;
    inc[IDX_LCV] = ev_lcv || (cfg.xz_inc && ev_xz);
    if (line_e1)         inc[IDX_FRM] = ev_ft_err;
    else if (cfg.mf_sel) inc[IDX_FRM] = ev_mf_loss;
    else                 inc[IDX_FRM] = ev_ft_err || (cfg.fs_rep && ev_fs_err);
  end

  errcnt_cnt_bank #(.N(NCNT), .CW(CW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .latch (upd),
    .run   (run_vec),
    .hold  (hold_vec),
    .done  (upd_done)
  );

  assign lcv_run   = run_vec[IDX_LCV*CW +: CW];
  assign frm_run   = run_vec[IDX_FRM*CW +: CW];
  assign lcv_count = hold_vec[IDX_LCV*CW +: CW];
  assign frm_count = hold_vec[IDX_FRM*CW +: CW];

endmodule

// File: rtl/errcnt_latch_chk.sv
module errcnt_latch_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd,
  input logic          done,
  input logic [CW-1:0] lcv_run,
  input logic [CW-1:0] frm_run,
  input logic [CW-1:0] lcv_hold,
  input logic [CW-1:0] frm_hold
);

  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  p_done_follows_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> done);

  p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcv_hold == $past(lcv_run)) && (frm_hold == $past(frm_run)));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(lcv_hold) && $stable(frm_hold));

  p_new_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lcv_run <= CW'(1)) && (frm_run <= CW'(1)));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(lcv_run) == MAXV) |-> lcv_run == MAXV);

  p_no_wrap_frm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(frm_run) == MAXV) |-> frm_run == MAXV);

endmodule

bind errcnt_latch_ctrl errcnt_latch_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd      (upd),
  .done     (upd_done),
  .lcv_run  (lcv_run),
  .frm_run  (frm_run),
  .lcv_hold (lcv_count),
  .frm_hold (frm_count)
);

// File: tb/errcnt_latch_ctrl_tb.sv
module errcnt_latch_ctrl_tb;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          line_e1 = 1'b0, sec_tick = 1'b0, sec_shared = 1'b0;
  logic          frame_tick = 1'b0, ext_latch = 1'b0;
  logic          ev_lcv = 1'b0, ev_xz = 1'b0, ev_ft_err = 1'b0;
  logic          ev_fs_err = 1'b0, ev_mf_loss = 1'b0;
  logic [CW-1:0] lcv_count, frm_count;
  logic          upd_done;

  int n_chk = 0, n_fail = 0, done_cnt = 0, d0 = 0, h1 = 0, h2 = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  errcnt_latch_ctrl #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .line_e1(line_e1), .sec_tick(sec_tick), .sec_shared(sec_shared),
    .frame_tick(frame_tick), .ext_latch(ext_latch), .ev_lcv(ev_lcv),
    .ev_xz(ev_xz), .ev_ft_err(ev_ft_err), .ev_fs_err(ev_fs_err),
    .ev_mf_loss(ev_mf_loss), .lcv_count(lcv_count), .frm_count(frm_count),
    .upd_done(upd_done)
  );

  always @(posedge clk) if (rst_n && upd_done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // which: 0 lcv, 1 xz, 2 ft, 3 fs, 4 mf
  task automatic evs(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      ev_lcv = (which == 0); ev_xz = (which == 1); ev_ft_err = (which == 2);
      ev_fs_err = (which == 3); ev_mf_loss = (which == 4);
      @(negedge clk);
    end
    {ev_lcv, ev_xz, ev_ft_err, ev_fs_err, ev_mf_loss} = '0;
  endtask

  task automatic tick_latch();
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; cyc(3);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1; @(negedge clk);
    end
    frame_tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    // R1 reset state
    chk(lcv_count == 0 && frm_count == 0, "R1 holds zero", int'(lcv_count), 0);
    chk(upd_done == 1'b0, "R1 done low", int'(upd_done), 0);

    // R2 / R3 exact latency with default config
    evs(0, 5); evs(2, 3); cyc(2);
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    chk(upd_done == 1'b0, "R2 done not yet", int'(upd_done), 0);
    @(negedge clk);
    chk(upd_done == 1'b1, "R2 done after two edges", int'(upd_done), 1);
    chk(lcv_count == 5, "R3 lcv snapshot", int'(lcv_count), 5);
    chk(frm_count == 3, "R3 frm snapshot", int'(frm_count), 3);
    @(negedge clk);
    chk(upd_done == 1'b0, "R2 done one cycle", int'(upd_done), 0);
    cyc(5);
    chk(lcv_count == 5, "R3 hold stable", int'(lcv_count), 5);

    // R12 excessive zeros
    evs(1, 4); evs(0, 2); tick_latch();
    chk(lcv_count == 2, "R12 xz excluded", int'(lcv_count), 2);
    wr_cfg(8'h20); evs(1, 4); evs(0, 2); tick_latch();
    chk(lcv_count == 6, "R12 xz included", int'(lcv_count), 6);

    // R13 framing counter selection
    for (int m = 0; m < 4; m++) begin
      int exp;
      wr_cfg(m == 0 ? 8'h00 : (m == 2 ? 8'h80 : 8'h40));
      line_e1 = (m == 3);
      tick_latch();
      evs(2, 3); evs(3, 4); evs(4, 2); tick_latch();
      exp = (m == 0) ? 3 : (m == 1) ? 7 : (m == 2) ? 2 : 3;
      chk(int'(frm_count) == exp, "R13 framing select", int'(frm_count), exp);
    end
    line_e1 = 1'b0; wr_cfg(8'h00); tick_latch();

    // R5 saturation
    evs(0, 300); tick_latch();
    chk(lcv_count == 255, "R5 saturate", int'(lcv_count), 255);
    chk(frm_count == 0, "R5 other counter", int'(frm_count), 0);

    // R4 event on latch edge goes to new period
    h1 = -1;
    for (int i = 0; i < 40; i++) begin
      if (upd_done) h1 = int'(lcv_count);
      ev_lcv = 1'b1; sec_tick = (i == 20);
      @(negedge clk);
    end
    ev_lcv = 1'b0; sec_tick = 1'b0; cyc(3);
    tick_latch(); h2 = int'(lcv_count);
    chk(h1 == 21, "R4 first period", h1, 21);
    chk(h2 == 19, "R4 second period", h2, 19);

    // R6 frame intervals
    wr_cfg(8'h02); cyc(3); d0 = done_cnt;
    frames(332); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; cyc(3);
    chk(done_cnt == d0, "R6 T1 before 333", done_cnt - d0, 0);
    frames(1); cyc(3);
    chk(done_cnt == d0 + 1, "R6 T1 at 333", done_cnt - d0, 1);
    line_e1 = 1'b1; cyc(3); d0 = done_cnt;
    frames(499); cyc(3);
    chk(done_cnt == d0, "R6 E1 before 500", done_cnt - d0, 0);
    frames(1); cyc(3);
    chk(done_cnt == d0 + 1, "R6 E1 at 500", done_cnt - d0, 1);

    // R7 restart on mode change and on interval-select change
    line_e1 = 1'b0; cyc(3); frames(200);
    line_e1 = 1'b1; cyc(3); d0 = done_cnt;
    frames(499); cyc(3);
    chk(done_cnt == d0, "R7 mode restart", done_cnt - d0, 0);
    frames(1); cyc(3);
    chk(done_cnt == d0 + 1, "R7 full interval", done_cnt - d0, 1);
    frames(100); wr_cfg(8'h00); cyc(2); wr_cfg(8'h02); cyc(3); d0 = done_cnt;
    frames(499); cyc(3);
    chk(done_cnt == d0, "R7 select restart", done_cnt - d0, 0);
    frames(1); cyc(3);
    chk(done_cnt == d0 + 1, "R7 select full", done_cnt - d0, 1);
    line_e1 = 1'b0;

    // R10 shared second
    wr_cfg(8'h10); cyc(2); d0 = done_cnt;
    tick_latch(); cyc(1);
    chk(done_cnt == d0, "R10 local ignored", done_cnt - d0, 0);
    sec_shared = 1'b1; cyc(4);
    chk(done_cnt == d0 + 1, "R10 shared rise", done_cnt - d0, 1);
    cyc(10);
    chk(done_cnt == d0 + 1, "R10 level held", done_cnt - d0, 1);
    sec_shared = 1'b0; cyc(4);
    chk(done_cnt == d0 + 1, "R10 fall ignored", done_cnt - d0, 1);

    // R11 manual mode ignores timers
    wr_cfg(8'h01); cyc(2); d0 = done_cnt;
    tick_latch(); sec_shared = 1'b1; cyc(3); sec_shared = 1'b0;
    wr_cfg(8'h03); cyc(2); frames(600); cyc(3);
    chk(done_cnt == d0, "R11 timers ignored", done_cnt - d0, 0);

    // R8 software toggle
    wr_cfg(8'h01); cyc(2); evs(0, 7); cyc(1); d0 = done_cnt;
    wr_cfg(8'h05); cyc(4);
    chk(done_cnt == d0 + 1, "R8 one latch", done_cnt - d0, 1);
    chk(lcv_count == 7, "R8 count", int'(lcv_count), 7);
    wr_cfg(8'h05); cyc(4);
    chk(done_cnt == d0 + 1, "R8 rewrite one", done_cnt - d0, 1);
    wr_cfg(8'h01); cyc(4);
    chk(done_cnt == d0 + 1, "R8 clear bit", done_cnt - d0, 1);

    // R9 external latch
    wr_cfg(8'h09); cyc(2); d0 = done_cnt;
    wr_cfg(8'h0D); cyc(4);
    chk(done_cnt == d0, "R9 toggle ignored", done_cnt - d0, 0);
    evs(2, 4); ext_latch = 1'b1; cyc(4);
    chk(done_cnt == d0 + 1, "R9 ext rise", done_cnt - d0, 1);
    chk(frm_count == 4, "R9 ext count", int'(frm_count), 4);
    cyc(6);
    chk(done_cnt == d0 + 1, "R9 ext level held", done_cnt - d0, 1);
    ext_latch = 1'b0; wr_cfg(8'h01); cyc(3);
    ext_latch = 1'b1; cyc(4);
    chk(done_cnt == d0 + 1, "R9 ext unselected", done_cnt - d0, 1);
    ext_latch = 1'b0; cyc(2);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule